// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a software-kicked watchdog. A single control byte sets its period and its action on timeout. The two low bits pick a resolution step of a power of four. Bits 6:2 give a multiplier. The period, counted in ticks of a 16 Hz enable, is the multiplier times four raised to the resolution code. Bit 7 is a steering bit. When it is clear, a timeout raises a one-cycle interrupt pulse. When it is set, a timeout raises a one-cycle system reset request.

Software arms or re-arms the timer by writing the control byte. It services the timer by reading that byte back, and each read starts the countdown again from the full period. A sticky timeout flag appears as bit 7 of a separate read-only flags register. A reset-steered timeout also disarms the watchdog. It then drives a strobe that a neighbouring calendar block uses to clear bit 6 of its day register.

Top module: `wdt_encoded_top`

## Requirements
- R1: After a synchronous active-low reset, the control byte is 0x00, the timeout flag is 0, and the interrupt, reset-request and clear-strobe outputs are low.
- R2: A timeout occurs on the Nth 16 Hz tick after a control-byte write, where N = bits[6:2] x 4^bits[1:0]. Its pulse appears in the clock cycle after that tick is sampled, and no pulse appears on earlier ticks.
- R3: When the computed period is zero, the watchdog is disabled and no ticks produce a timeout. This covers writing 0x00 and any byte whose multiplier field is zero.
- R4: A write of the control byte stores the byte, clears the timeout flag and restarts the countdown. A write in the same cycle as a tick takes priority over that tick.
- R5: A read of the control byte returns the stored byte on rd_data one cycle later. It reloads the countdown with the full period and clears the timeout flag.
- R6: A timeout sets the flag. wd_flag is high, and a flags read returns 0x80, with the flag in bit 7 and the other bits zero.
- R7: On a timeout with control bit 7 set, reset_req and century_clr each pulse high for exactly one cycle, and irq_pulse stays low. The control byte becomes 0x00, so the watchdog stops.
- R8: On a timeout with control bit 7 clear, irq_pulse is high for exactly one cycle and reset_req stays low. The countdown does not restart by itself: no further timeout occurs until the next write or read.
- R9: A write to the flags register has no effect on the timeout flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16hz | input | 1 | One-cycle enable at 16 Hz; counting time base |
| wdog_wr | input | 1 | Write strobe for the control byte |
| wdog_rd | input | 1 | Read strobe for the control byte (kick) |
| flags_wr | input | 1 | Write strobe for the flags register (ignored) |
| flags_rd | input | 1 | Read strobe for the flags register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the last read strobe |
| irq_pulse | output | 1 | One-cycle interrupt on an interrupt-steered timeout |
| reset_req | output | 1 | One-cycle system reset request on a reset-steered timeout |
| century_clr | output | 1 | One-cycle strobe to clear bit 6 of the day register |
| wd_flag | output | 1 | Sticky timeout flag (flags register bit 7) |

## Verification
The assertions assume that the host never raises the control-byte write and read strobes in the same cycle. They also assume that the tick is a single-cycle enable, not a level. Under those conditions, a pulse can only follow a sampled tick, and a write can never leave the flag set. The stimulus drives at most one strobe per task call. It returns every strobe, and the tick, to low before the next operation, so it never leaves these assumptions.

// File: rtl/wdt_pkg.sv
// Shared types for the encoded-interval watchdog.
// Assumes nothing beyond a common clock domain.
package wdt_pkg;

    // Action taken on the cycle a timeout is detected
    typedef enum logic [1:0] {
        WDT_ACT_NONE  = 2'd0,
        WDT_ACT_IRQ   = 2'd1,
        WDT_ACT_RESET = 2'd2
    } wdt_action_e;

endpackage

// File: rtl/wdt_interval_dec.sv
// Turns a control byte into a period in ticks: multiplier << (2*resolution).
// Assumes CNT_W is large enough for the largest multiplier at the top step.
module wdt_interval_dec #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int BYTE_W = 1 + MULT_W + RES_W,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [BYTE_W-1:0] cfg_byte,
    output logic [CNT_W-1:0]  period
);

    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
    logic [CNT_W-1:0]  mult_ext;

    // Split the byte into its two fields; the top bit (steering) is not used here
    always_comb begin
        mult     = cfg_byte[RES_W +: MULT_W];
        res      = cfg_byte[RES_W-1:0];
        mult_ext = CNT_W'(mult);
    end

    // One shifter stage per resolution bit: stage k shifts by 2*2^k
    logic [CNT_W-1:0] stage [RES_W+1];
    assign stage[0] = mult_ext;
    for (genvar k = 0; k < RES_W; k++) begin : g_shift
        assign stage[k+1] = res[k] ? (stage[k] << (2 * (1 << k))) : stage[k];
    end
    assign period = stage[RES_W];

    logic unused_steer;
    assign unused_steer = cfg_byte[BYTE_W-1];

endmodule

// File: rtl/wdt_countdown.sv
// Tick-driven down counter. A load sets the count, and zero means idle.
// Expiry is flagged on the tick that takes the count from 1 to 0.
// Assumes the load takes priority over a tick in the same cycle.
module wdt_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Count state: reload, decrement on tick while non-zero, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry is seen in the cycle of the last tick, unless a reload overrides it
    assign expire = tick && !load && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/wdt_ctrl.sv
// Holds the control byte and the sticky flag. It decides the timeout action,
// registers the three output pulses and the read data, and issues reloads.
// Assumes the write and read strobes of the control byte are never both high.
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic              flg_wr,
    input  logic              flg_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              expire,
    output logic              load,
    output logic [BYTE_W-1:0] load_src,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_q,
    output logic              rst_req_q,
    output logic              clr_q,
    output logic              flag_q
);

    logic [BYTE_W-1:0] cfg_q;
    wdt_action_e       act;

    // Steering bit (MSB) picks the action when the counter expires
    always_comb begin
        if (!expire)                act = WDT_ACT_NONE;
        else if (cfg_q[BYTE_W-1])   act = WDT_ACT_RESET;
        else                        act = WDT_ACT_IRQ;
    end

    // A reload comes from a write (new byte) or a read kick (stored byte)
    assign load     = cfg_wr || cfg_rd;
    assign load_src = cfg_wr ? wdata : cfg_q;

    // Control byte: written by the host, cleared by a reset-steered timeout
    always_ff @(posedge clk) begin
        if (!rst_n)                     cfg_q <= '0;
        else if (cfg_wr)                cfg_q <= wdata;
        else if (act == WDT_ACT_RESET)  cfg_q <= '0;
    end

    // Sticky flag: reloads clear it, a timeout sets it, flags writes leave it
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (load)                  flag_q <= 1'b0;
        else if (act != WDT_ACT_NONE)   flag_q <= 1'b1;
        else if (flg_wr)                flag_q <= flag_q;
    end

    // Single-cycle output pulses, one cycle after the expiring tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            rst_req_q <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            irq_q     <= (act == WDT_ACT_IRQ);
            rst_req_q <= (act == WDT_ACT_RESET);
            clr_q     <= (act == WDT_ACT_RESET);
        end
    end

    // Registered read data for either readable register
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (cfg_rd)  rdata <= cfg_q;
        else if (flg_rd)  rdata <= {flag_q, {(BYTE_W-1){1'b0}}};
    end

endmodule

// File: rtl/wdt_encoded_top.sv
// Top of the encoded-interval watchdog. It connects the control register,
// the period decoder and the countdown.
// Assumes tick_16hz is a one-cycle enable and that all strobes are synchronous.
module wdt_encoded_top #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_16hz,
    input  logic                      wdog_wr,
    input  logic                      wdog_rd,
    input  logic                      flags_wr,
    input  logic                      flags_rd,
    input  logic [MULT_W+RES_W:0]     wr_data,
    output logic [MULT_W+RES_W:0]     rd_data,
    output logic                      irq_pulse,
    output logic                      reset_req,
    output logic                      century_clr,
    output logic                      wd_flag
);

    localparam int BYTE_W = 1 + MULT_W + RES_W;
    localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

    logic              load;
    logic [BYTE_W-1:0] load_src;
    logic [CNT_W-1:0]  period;
    logic              expire;

    wdt_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wdog_wr),
        .cfg_rd    (wdog_rd),
        .flg_wr    (flags_wr),
        .flg_rd    (flags_rd),
        .wdata     (wr_data),
        .expire    (expire),
        .load      (load),
        .load_src  (load_src),
        .rdata     (rd_data),
        .irq_q     (irq_pulse),
        .rst_req_q (reset_req),
        .clr_q     (century_clr),
        .flag_q    (wd_flag)
    );

    wdt_interval_dec #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) u_dec (
        .cfg_byte (load_src),
        .period   (period)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (period),
        .tick     (tick_16hz),
        .expire   (expire)
    );

endmodule

// File: rtl/wdt_encoded_checker.sv
// Property checker for the watchdog, attached to the top module by bind.
// Assumes the host does not raise the control-byte write and read strobes together.
module wdt_encoded_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_16hz,
    input logic wdog_wr,
    input logic wdog_rd,
    input logic flags_wr,
    input logic irq_pulse,
    input logic reset_req,
    input logic century_clr,
    input logic wd_flag
);

    a_r7_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r7_steer_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse && reset_req));

    a_r7_clear_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> century_clr);

    a_r6_flag_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse || reset_req) |-> wd_flag);

    a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse || reset_req) |-> $past(tick_16hz));

    a_r4_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_wr |=> !wd_flag);

    a_r9_flags_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_wr && !wdog_wr && !wdog_rd && !tick_16hz) |=> $stable(wd_flag));

endmodule

bind wdt_encoded_top wdt_encoded_checker i_wdt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_16hz   (tick_16hz),
    .wdog_wr     (wdog_wr),
    .wdog_rd     (wdog_rd),
    .flags_wr    (flags_wr),
    .irq_pulse   (irq_pulse),
    .reset_req   (reset_req),
    .century_clr (century_clr),
    .wd_flag     (wd_flag)
);

// File: tb/test_wdt_encoded_top.sv
// Self-checking bench: a table of control bytes with expected periods, then directed cases.
module test_wdt_encoded_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16hz = 1'b0;
    logic       wdog_wr = 1'b0;
    logic       wdog_rd = 1'b0;
    logic       flags_wr = 1'b0;
    logic       flags_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_pulse;
    logic       reset_req;
    logic       century_clr;
    logic       wd_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wdt_encoded_top i_wdt_encoded_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_16hz   (tick_16hz),
        .wdog_wr     (wdog_wr),
        .wdog_rd     (wdog_rd),
        .flags_wr    (flags_wr),
        .flags_rd    (flags_rd),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .irq_pulse   (irq_pulse),
        .reset_req   (reset_req),
        .century_clr (century_clr),
        .wd_flag     (wd_flag)
    );

    // {control byte, expected period in ticks}
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {8'h04, 16'd1},
        {8'h05, 16'd4},
        {8'h0B, 16'd128},
        {8'h7C, 16'd31},
        {8'h7F, 16'd1984},
        {8'h8E, 16'd48},
        {8'h12, 16'd64},
        {8'hA1, 16'd32}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(logic [7:0] v);
        @(negedge clk); wdog_wr = 1'b1; wr_data = v;
        @(negedge clk); wdog_wr = 1'b0;
    endtask

    task automatic rd_cfg(output logic [7:0] v);
        @(negedge clk); wdog_rd = 1'b1;
        @(negedge clk); wdog_rd = 1'b0; v = rd_data;
    endtask

    task automatic rd_flags(output logic [7:0] v);
        @(negedge clk); flags_rd = 1'b1;
        @(negedge clk); flags_rd = 1'b0; v = rd_data;
    endtask

    task automatic tick1(output logic i, output logic r, output logic c);
        @(negedge clk); tick_16hz = 1'b1;
        @(negedge clk); tick_16hz = 1'b0;
        i = irq_pulse; r = reset_req; c = century_clr;
    endtask

    // Ticks n times, returns how many ticks showed any pulse
    task automatic quiet_ticks(int n, output int hits);
        logic i, r, c;
        hits = 0;
        for (int t = 0; t < n; t++) begin
            tick1(i, r, c);
            if (i || r || c) hits++;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic i, r, c;
        int hits;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 wd_flag", wd_flag, 0);
        chk("R1 irq_pulse", irq_pulse, 0);
        chk("R1 reset_req", reset_req, 0);
        chk("R1 century_clr", century_clr, 0);
        rd_cfg(v);
        chk("R1 control byte", v, 8'h00);
        quiet_ticks(20, hits);
        chk("R1 disabled after reset", hits, 0);

        // Table walk: R2 period, R4 write, R6 flag, R7/R8 steering
        for (int k = 0; k < NV; k++) begin
            logic [7:0] b;
            int n;
            b = VEC[k][23:16];
            n = int'(VEC[k][15:0]);
            wr_cfg(b);
            chk("R4 write clears flag", wd_flag, 0);
            quiet_ticks(n - 1, hits);
            chk("R2 no early timeout", hits, 0);
            tick1(i, r, c);
            chk("R8 irq on timeout", i, !b[7]);
            chk("R7 reset_req on timeout", r, b[7]);
            chk("R7 century_clr on timeout", c, b[7]);
            chk("R6 flag set", wd_flag, 1);
            @(negedge clk);
            chk("R7 R8 single-cycle pulse", {irq_pulse, reset_req, century_clr}, 0);
            rd_flags(v);
            chk("R6 flags read", v, 8'h80);
            rd_cfg(v);
            chk(b[7] ? "R7 byte cleared" : "R5 readback", v, b[7] ? 8'h00 : b);
        end

        // R3: zero byte and zero multiplier disable
        wr_cfg(8'h00);
        quiet_ticks(100, hits);
        chk("R3 zero byte disabled", hits, 0);
        wr_cfg(8'h03);
        quiet_ticks(100, hits);
        chk("R3 zero multiplier disabled", hits, 0);
        wr_cfg(8'h83);
        quiet_ticks(100, hits);
        chk("R3 zero multiplier with steer", hits, 0);

        // R5: kick reloads the full period
        wr_cfg(8'h14);
        quiet_ticks(3, hits);
        rd_cfg(v);
        chk("R5 kick readback", v, 8'h14);
        quiet_ticks(4, hits);
        chk("R5 kick delays timeout", hits, 0);
        tick1(i, r, c);
        chk("R5 timeout after reload", i, 1);

        // R8: one-shot, no re-arm after an interrupt timeout
        quiet_ticks(30, hits);
        chk("R8 no repeat without kick", hits, 0);

        // R9: flags write ignored
        @(negedge clk); flags_wr = 1'b1; wr_data = 8'h00;
        @(negedge clk); flags_wr = 1'b0;
        chk("R9 flag kept", wd_flag, 1);
        rd_flags(v);
        chk("R9 flags read", v, 8'h80);

        // R5: read clears flag
        rd_cfg(v);
        chk("R5 read clears flag", wd_flag, 0);

        // R4: write in same cycle as the final tick wins
        wr_cfg(8'h04);
        @(negedge clk); tick_16hz = 1'b1; wdog_wr = 1'b1; wr_data = 8'h08;
        @(negedge clk); tick_16hz = 1'b0; wdog_wr = 1'b0;
        chk("R4 write beats tick", irq_pulse, 0);
        quiet_ticks(1, hits);
        chk("R4 restarted period", hits, 0);
        tick1(i, r, c);
        chk("R4 timeout of new period", i, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule